// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside a small processor and decides when it must leave its instruction stream to service one of five interrupt sources. Each source has a bit in a flag register and a bit in an enable register, and both are reachable over a register bus. Hardware sets a flag bit with a one-cycle pulse. Software can write the flag register to raise or drop any bit. A source counts as pending only while both its flag bit and its enable bit are 1.

A master enable gates dispatch. The processor changes it through three command pulses: delayed enable, disable, and return-from-interrupt. At every instruction boundary the processor raises a strobe. If the master enable is on and a source is pending, the controller takes the interrupt in that same cycle. It picks the lowest-numbered pending source, clears that source's flag bit and clears the master enable.

After two idle cycles the controller presents a call request together with the 16-bit vector. It holds both until the processor acknowledges. A separate wake output ends halt mode whenever any source is pending, whether or not the master enable is on.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the flag register reads 0xE0, the enable register reads 0x00, the master enable is off, and wake, busy and call request are all 0.
- R2: The bus selects the flag register with `reg_sel`=0 and the enable register with `reg_sel`=1. The flag register reads its five bits in positions 4..0 with bits 7..5 always 1. The enable register reads its five bits with bits 7..5 at 0. A write replaces all five low bits, so it can set or clear any of them.
- R3: A set pulse on `src_set[i]` makes flag bit i equal to 1. If it arrives in the same cycle as a flag write, the pulse wins for that bit.
- R4: `wake` is 1 whenever any bit is set in both the flag and the enable register, including while the master enable is off. With the master enable off, a boundary takes no interrupt.
- R5: Of the pending sources, the one with the lowest bit index is served first. Bit 0 is vertical blank, bit 1 display status, bit 2 timer, bit 3 serial and bit 4 keypad. The vector is 0x0040 + 8 × index.
- R6: Taking an interrupt clears only the served flag bit and turns the master enable off. A flag bit whose enable bit is 0 stays set until software clears it.
- R7: A delayed-enable command has no effect at the next boundary. The master enable turns on as that boundary passes, so the boundary after it can dispatch.
- R8: A disable command turns the master enable off and cancels any delayed enable that has not yet taken effect.
- R9: A return-from-interrupt command turns the master enable on at once, so the very next boundary can dispatch.
- R10: A dispatch decided at boundary edge E0 leaves `call_req` at 0 for two cycles and raises it after edge E0+2. `call_req` and the vector stay steady until `call_ack`. Boundaries are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 5 | Per-source set pulses from hardware |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| reg_wdata | input | 5 | Write data for the five source bits |
| reg_rdata | output | 8 | Read data of the selected register |
| cmd_ei | input | 1 | Delayed master-enable command pulse |
| cmd_di | input | 1 | Master-disable command pulse |
| cmd_reti | input | 1 | Return-from-interrupt command pulse |
| boundary | input | 1 | Instruction-boundary strobe |
| irq_take | output | 1 | This boundary takes an interrupt |
| wake | output | 1 | Ends halt mode; some enabled source is flagged |
| busy | output | 1 | Dispatch sequence in progress |
| call_req | output | 1 | Call may start; vector is valid |
| call_ack | input | 1 | Processor accepts the call |
| vector | output | 16 | Service address, valid with call_req |

## Verification
The hardest states to reach are those that depend on timing across several cycles. One is the delayed enable that is still waiting when a disable command arrives. Another is a boundary strobe that lands in the middle of a dispatch. A third is a hardware pulse that coincides with a software write to the flag register. The stimulus builds each of these by issuing the commands one cycle apart and then offering two boundaries in a row. Because a boundary that dispatches looks different from one that does not, the state of the master enable can be read from the ports. During every dispatch the driver also raises a second boundary strobe in the first idle cycle and expects it to be refused.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        DSP_IDLE = 2'd0,
        DSP_GAP  = 2'd1,
        DSP_CALL = 2'd2
    } dsp_state_e;

    localparam logic REG_SEL_FLAG = 1'b0;
    localparam logic REG_SEL_MASK = 1'b1;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NSRC  = 5,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  req,
    output logic             any,
    output logic [NSRC-1:0]  gnt,
    output logic [IDX_W-1:0] idx
);
    logic [NSRC:0] lower;

    assign lower[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign gnt[i]     = req[i] & ~lower[i];
        assign lower[i+1] = lower[i] | req[i];
    end

    assign any = lower[NSRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (gnt[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
    parameter int              NSRC     = 5,
    parameter int              IDX_W    = $clog2(NSRC),
    parameter int              VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0040,
    parameter int              VEC_STEP = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [VEC_W-1:0] vec
);
    localparam logic [VEC_W-1:0] STEP_V = VEC_W'(VEC_STEP);

    always_comb begin
        vec = VEC_BASE + VEC_W'(idx) * STEP_V;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int               NSRC     = 5,
    parameter int               DATA_W   = 8,
    parameter int               VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0040,
    parameter int               VEC_STEP = 8,
    parameter int               GAP_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_set,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              cmd_reti,
    input  logic              boundary,
    output logic              irq_take,
    output logic              wake,
    output logic              busy,
    output logic              call_req,
    input  logic              call_ack,
    output logic [VEC_W-1:0]  vector
);
    import irq_pkg::*;

    localparam int IDX_W = $clog2(NSRC);
    localparam int CNT_W = $clog2(GAP_CYC + 1);
    localparam int PAD_W = DATA_W - NSRC;

    typedef struct packed {
        logic [NSRC-1:0]  flag;
        logic [NSRC-1:0]  mask;
        logic             master;
        logic             ei_wait;
        dsp_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  gnt;
    logic             pend_any;
    logic [IDX_W-1:0] pick_idx;
    logic [VEC_W-1:0] vec_calc;
    logic             idle;
    logic             master_q;

    assign pend     = s_q.flag & s_q.mask;
    assign idle     = (s_q.st == DSP_IDLE);
    assign master_q = s_q.master;

    irq_lowest_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .req (pend),
        .any (pend_any),
        .gnt (gnt),
        .idx (pick_idx)
    );

    irq_vec_calc #(
        .NSRC(NSRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_vec (
        .idx (s_q.idx),
        .vec (vec_calc)
    );

    assign wake     = pend_any;
    assign irq_take = boundary && idle && s_q.master && pend_any;
    assign busy     = !idle;
    assign call_req = (s_q.st == DSP_CALL);
    assign vector   = call_req ? vec_calc : '0;

    always_comb begin
        if (reg_sel == REG_SEL_FLAG) reg_rdata = {{PAD_W{1'b1}}, s_q.flag};
        else                         reg_rdata = {{PAD_W{1'b0}}, s_q.mask};
    end

    always_comb begin
        s_d = s_q;

        // delayed enable matures as a boundary passes
        if (boundary && idle && s_q.ei_wait) begin
            s_d.master  = 1'b1;
            s_d.ei_wait = 1'b0;
        end
        if (cmd_reti) s_d.master  = 1'b1;
        if (cmd_ei)   s_d.ei_wait = 1'b1;
        if (cmd_di) begin
            s_d.master  = 1'b0;
            s_d.ei_wait = 1'b0;
        end

        if (reg_we && reg_sel == REG_SEL_FLAG) s_d.flag = reg_wdata;
        if (reg_we && reg_sel == REG_SEL_MASK) s_d.mask = reg_wdata;

        case (s_q.st)
            DSP_IDLE: begin
                if (irq_take) begin
                    s_d.flag    = s_d.flag & ~gnt;
                    s_d.master  = 1'b0;
                    s_d.ei_wait = 1'b0;
                    s_d.idx     = pick_idx;
                    s_d.cnt     = '0;
                    s_d.st      = DSP_GAP;
                end
            end
            DSP_GAP: begin
                if (s_q.cnt == CNT_W'(GAP_CYC - 1)) s_d.st  = DSP_CALL;
                else                                 s_d.cnt = s_q.cnt + 1'b1;
            end
            DSP_CALL: begin
                if (call_ack) s_d.st = DSP_IDLE;
            end
            default: s_d.st = DSP_IDLE;
        endcase

        // hardware pulses have the last word on flag bits
        s_d.flag = s_d.flag | src_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{flag: '0, mask: '0, master: 1'b0, ei_wait: 1'b0,
                     st: DSP_IDLE, cnt: '0, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_take,
    input logic wake,
    input logic busy,
    input logic call_req,
    input logic call_ack,
    input logic cmd_di,
    input logic master_q
);
    // R4
    take_has_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> wake);

    // R6
    take_clears_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !master_q);

    // R8
    disable_clears_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_di |=> !master_q);

    // R10
    call_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !call_ack) |=> call_req);

    // R10
    busy_refuses_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_take);

    // R10
    call_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> ($past(busy) && $past(busy, 2)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_take (irq_take),
    .wake     (wake),
    .busy     (busy),
    .call_req (call_req),
    .call_ack (call_ack),
    .cmd_di   (cmd_di),
    .master_q (master_q)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_set = '0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [4:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cmd_ei = 1'b0, cmd_di = 1'b0, cmd_reti = 1'b0;
    logic        boundary = 1'b0;
    logic        irq_take, wake, busy, call_req;
    logic        call_ack = 1'b0;
    logic [15:0] vector;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_reti(cmd_reti),
        .boundary(boundary), .irq_take(irq_take), .wake(wake), .busy(busy),
        .call_req(call_req), .call_ack(call_ack), .vector(vector)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [4:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic sel, input logic [7:0] exp);
        reg_sel = sel;
        #0.5;
        chk(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic pulse(input logic [4:0] m);
        src_set = m;
        tick();
        src_set = '0;
    endtask

    task automatic cmd(input int which);
        cmd_ei = (which == 0); cmd_di = (which == 1); cmd_reti = (which == 2);
        tick();
        cmd_ei = 1'b0; cmd_di = 1'b0; cmd_reti = 1'b0;
    endtask

    task automatic bnd(input string req, input logic exp_take);
        boundary = 1'b1;
        #0.5;
        chk(req, {15'd0, irq_take}, {15'd0, exp_take});
        @(posedge clk); #1;
        boundary = 1'b0;
    endtask

    // driver side of a full dispatch; the monitor checks the vector
    task automatic dispatch(input string req, input logic [15:0] v);
        exp_q.push_back(v);
        bnd(req, 1'b1);
        chk("R10 busy after take", {15'd0, busy}, 16'd1);
        chk("R10 no call in gap 1", {15'd0, call_req}, 16'd0);
        bnd("R10 boundary ignored while busy", 1'b0);
        chk("R10 no call in gap 2", {15'd0, call_req}, 16'd0);
        tick();
        chk("R10 call raised", {15'd0, call_req}, 16'd1);
        tick();
        chk("R10 idle after ack", {15'd0, busy}, 16'd0);
    endtask

    // monitor: pops expected vectors and acknowledges calls
    initial begin
        forever begin
            @(posedge clk); #2;
            if (call_ack) begin
                call_ack = 1'b0;
            end else if (call_req) begin
                if (exp_q.size() == 0) begin
                    nchk++; nfail++;
                    $display("FAIL R5: actual vector %h expected none", vector);
                end else begin
                    chk("R5 vector", vector, exp_q.pop_front());
                end
                call_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        rd("R1 flag reset", 1'b0, 8'hE0);
        rd("R1 enable reset", 1'b1, 8'h00);
        chk("R1 wake reset", {15'd0, wake}, 16'd0);
        chk("R1 busy reset", {15'd0, busy}, 16'd0);
        chk("R1 call reset", {15'd0, call_req}, 16'd0);
        bnd("R1 master off after reset", 1'b0);

        // R2
        wr(1'b0, 5'h1F); rd("R2 flag all set", 1'b0, 8'hFF);
        wr(1'b0, 5'h0A); rd("R2 flag mixed", 1'b0, 8'hEA);
        wr(1'b1, 5'h1F); rd("R2 enable readback", 1'b1, 8'h1F);
        wr(1'b1, 5'h00); wr(1'b0, 5'h00);
        rd("R2 flag cleared", 1'b0, 8'hE0);

        // R3
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 5'h00; src_set = 5'h04;
        tick();
        reg_we = 1'b0; src_set = '0;
        rd("R3 pulse beats write", 1'b0, 8'hE4);
        pulse(5'h01); rd("R3 pulse sets", 1'b0, 8'hE5);
        wr(1'b0, 5'h00);

        // R4 and R6: disabled source stays latched, wake ignores master
        pulse(5'h08);
        rd("R6 disabled flag latched", 1'b0, 8'hE8);
        chk("R4 no wake when disabled", {15'd0, wake}, 16'd0);
        wr(1'b1, 5'h08);
        chk("R4 wake with master off", {15'd0, wake}, 16'd1);
        bnd("R4 no take with master off", 1'b0);
        chk("R4 not busy", {15'd0, busy}, 16'd0);
        rd("R4 flag untouched", 1'b0, 8'hE8);

        // R9, R5: reti enables at once, serial before keypad
        pulse(5'h10); wr(1'b1, 5'h18);
        cmd(2);
        dispatch("R9 reti then boundary takes", 16'h0058);
        rd("R6 only served bit cleared", 1'b0, 8'hF0);
        bnd("R6 master off after take", 1'b0);
        chk("R4 wake still set", {15'd0, wake}, 16'd1);

        // R7
        cmd(0);
        bnd("R7 no effect at next boundary", 1'b0);
        dispatch("R7 following boundary takes", 16'h0060);
        rd("R7 flag cleared", 1'b0, 8'hE0);
        chk("R7 wake clear", {15'd0, wake}, 16'd0);

        // R8
        cmd(0); cmd(1);
        wr(1'b1, 5'h1F); pulse(5'h02);
        bnd("R8 first boundary", 1'b0);
        bnd("R8 delayed enable cancelled", 1'b0);

        // R5 ordering across three sources
        pulse(5'h05);
        cmd(2); dispatch("R5 bit0 first", 16'h0040);
        rd("R5 remaining flags", 1'b0, 8'hE6);
        cmd(2); dispatch("R5 bit1 second", 16'h0048);
        cmd(2); dispatch("R5 bit2 third", 16'h0050);
        rd("R5 all served", 1'b0, 8'hE0);

        tick(); tick();
        chk("R5 scoreboard drained", 16'(exp_q.size()), 16'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule